// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits beside a nonvolatile-backed memory controller and watches the read traffic that reaches the array. Each access arrives as a single-cycle strobe with a write flag and an 11-bit address. When six reads arrive back to back at a fixed series of addresses, the block issues a one-clock request. The last address of the series picks one of two requests. One asks the controller to copy the volatile array into nonvolatile storage (save). The other asks it to reload the array from nonvolatile storage (restore).

Any write, any read off the expected path, or any repeat of an address breaks the series. An access that breaks the series is still tested as a possible first step. While the controller reports that it is busy, the block ignores all accesses and stays idle. The controller's output-enable state is not an input, so it cannot affect matching.

Top module: `seqd_seq_detect`

## Requirements
- R1: Reads at 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then 0x70F, with no other access between them, raise `store_req_o` for exactly the clock cycle after the sixth access is sampled.
- R2: The same first five reads followed by a read at 0x70E raise `recall_req_o` for exactly the clock cycle after the sixth access.
- R3: An access with `acc_is_write_i` = 1 aborts the series at any step, including the sixth, and produces no request.
- R4: A read whose address is not the next expected one aborts the series. If that read is at 0x000, it counts as step one.
- R5: The series ending in 0x39C produces no request of either kind.
- R6: Every strobe counts as a new access, so two reads of the same address in a row break the series.
- R7: A cycle with `busy_i` = 1 ignores any access, sends the matcher to idle and produces no request.
- R8: Each request lasts one cycle, and `store_req_o` and `recall_req_o` are never high together.
- R9: While `rst_ni` is low, both requests are low and the matcher is idle.
- R10: Cycles with `acc_vld_i` = 0 neither advance nor abort the series.
- R11: After a successful sixth step the matcher is idle, so a new request needs all six steps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | One-cycle strobe per chip-enable access |
| acc_is_write_i | input | 1 | 1 = the access is a write, 0 = read |
| addr_i | input | 11 | Access address |
| busy_i | input | 1 | Controller is busy with a transfer |
| store_req_o | output | 1 | One-cycle save request |
| recall_req_o | output | 1 | One-cycle restore request |

## Verification
Two events can coincide with a request. The first is the sixth access arriving in the same cycle that `busy_i` rises. The second is the request pulse overlapping the first access of the next series. The bench drives a sixth step with busy high and expects no pulse. It then runs a save series straight into a restore series with no idle cycle between them, and expects two separate single-cycle pulses of the right kinds. A scoreboard compares every cycle, so a stretched pulse, or a matcher that loses the step-one access sent during the pulse cycle, shows up as a mismatch.

// File: rtl/seqd_pkg.sv
package seqd_pkg;
    localparam int ADDR_W      = 11;
    localparam int PREFIX_LEN  = 5;
    localparam int STEP_W      = $clog2(PREFIX_LEN + 1);

    localparam logic [ADDR_W-1:0] STORE_TAIL  = 11'h70F;
    localparam logic [ADDR_W-1:0] RECALL_TAIL = 11'h70E;

    // expected address for prefix step idx (order is behaviour)
    function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
        case (idx)
            0:       prefix_addr = 11'h000;
            1:       prefix_addr = 11'h555;
            2:       prefix_addr = 11'h2AA;
            3:       prefix_addr = 11'h7FF;
            4:       prefix_addr = 11'h0F0;
            default: prefix_addr = '0;
        endcase
    endfunction

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              store;
        logic              recall;
    } seqd_state_t;
endpackage

// File: rtl/seqd_prefix_cmp.sv
module seqd_prefix_cmp
    import seqd_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LEN = PREFIX_LEN
) (
    input  logic [AW-1:0]  addr_i,
    output logic [LEN-1:0] hit_o
);
    for (genvar g = 0; g < LEN; g++) begin : g_cmp
        assign hit_o[g] = (addr_i == AW'(prefix_addr(g)));
    end
endmodule

// File: rtl/seqd_tail_dec.sv
module seqd_tail_dec #(
    parameter int              AW          = 11,
    parameter logic [AW-1:0]   STORE_CODE  = '0,
    parameter logic [AW-1:0]   RECALL_CODE = '0
) (
    input  logic [AW-1:0] addr_i,
    output logic          is_store_o,
    output logic          is_recall_o
);
    assign is_store_o  = (addr_i == STORE_CODE);
    assign is_recall_o = (addr_i == RECALL_CODE);
endmodule

// File: rtl/seqd_seq_detect.sv
module seqd_seq_detect
    import seqd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_vld_i,
    input  logic              acc_is_write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    output logic              store_req_o,
    output logic              recall_req_o
);
    localparam logic [STEP_W-1:0] STEP_IDLE  = '0;
    localparam logic [STEP_W-1:0] STEP_ONE   = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_FINAL = STEP_W'(PREFIX_LEN);

    seqd_state_t st_d, st_q;

    logic [PREFIX_LEN-1:0] prefix_hit;
    logic                  tail_store, tail_recall;
    logic                  step_hit;
    logic [STEP_W-1:0]     restart_step;

    seqd_prefix_cmp #(
        .AW  (ADDR_W),
        .LEN (PREFIX_LEN)
    ) prefix_cmp_i (
        .addr_i (addr_i),
        .hit_o  (prefix_hit)
    );

    seqd_tail_dec #(
        .AW          (ADDR_W),
        .STORE_CODE  (STORE_TAIL),
        .RECALL_CODE (RECALL_TAIL)
    ) tail_dec_i (
        .addr_i      (addr_i),
        .is_store_o  (tail_store),
        .is_recall_o (tail_recall)
    );

    // pick the comparator for the step now expected
    always_comb begin
        step_hit = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (st_q.step == STEP_W'(i)) step_hit = prefix_hit[i];
        end
    end

    // a breaking read may itself be a fresh step one
    assign restart_step = prefix_hit[0] ? STEP_ONE : STEP_IDLE;

    always_comb begin
        st_d        = st_q;
        st_d.store  = 1'b0;
        st_d.recall = 1'b0;
        if (busy_i) begin
            st_d.step = STEP_IDLE;
        end else if (acc_vld_i) begin
            if (acc_is_write_i) begin
                st_d.step = STEP_IDLE;
            end else if (st_q.step == STEP_FINAL) begin
                if (tail_store) begin
                    st_d.store = 1'b1;
                    st_d.step  = STEP_IDLE;
                end else if (tail_recall) begin
                    st_d.recall = 1'b1;
                    st_d.step   = STEP_IDLE;
                end else begin
                    st_d.step = restart_step;
                end
            end else if (st_q.step < STEP_FINAL && step_hit) begin
                st_d.step = st_q.step + STEP_ONE;
            end else begin
                st_d.step = restart_step;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign store_req_o  = st_q.store;
    assign recall_req_o = st_q.recall;
endmodule

// File: rtl/seqd_chk.sv
module seqd_chk
    import seqd_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              acc_vld_i,
    input logic              acc_is_write_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              busy_i,
    input logic              store_req_o,
    input logic              recall_req_o
);
    // R1
    store_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store_req_o |-> $past(acc_vld_i && !acc_is_write_i && !busy_i && addr_i == STORE_TAIL));
    // R2
    recall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recall_req_o |-> $past(acc_vld_i && !acc_is_write_i && !busy_i && addr_i == RECALL_TAIL));
    // R3
    write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_vld_i && acc_is_write_i) |=> !(store_req_o || recall_req_o));
    // R5
    test_code_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_vld_i && addr_i == 11'h39C) |=> !(store_req_o || recall_req_o));
    // R7
    busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> !(store_req_o || recall_req_o));
    // R8
    one_hot_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({store_req_o, recall_req_o}));
    // R8
    store_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store_req_o |=> !store_req_o);
    // R8
    recall_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recall_req_o |=> !recall_req_o);
    // R10
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_vld_i |=> !(store_req_o || recall_req_o));
endmodule

bind seqd_seq_detect seqd_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_vld_i      (acc_vld_i),
    .acc_is_write_i (acc_is_write_i),
    .addr_i         (addr_i),
    .busy_i         (busy_i),
    .store_req_o    (store_req_o),
    .recall_req_o   (recall_req_o)
);

// File: tb/seqd_seq_detect_tb_top.sv
module seqd_seq_detect_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        acc_vld_i = 1'b0;
    logic        acc_is_write_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic        busy_i = 1'b0;
    logic        store_req_o, recall_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;

    typedef struct {
        bit    es;
        bit    er;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk_i = ~clk_i;  // 125 MHz

    seqd_seq_detect dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .acc_vld_i      (acc_vld_i),
        .acc_is_write_i (acc_is_write_i),
        .addr_i         (addr_i),
        .busy_i         (busy_i),
        .store_req_o    (store_req_o),
        .recall_req_o   (recall_req_o)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: one cycle per call, expectation pushed for that cycle
    task automatic drive(input bit vld, input logic [10:0] a, input bit wr,
                         input bit bz, input bit es, input bit er, input string tag);
        @(negedge clk_i);
        acc_vld_i      = vld;
        addr_i         = a;
        acc_is_write_i = wr;
        busy_i         = bz;
        sb_q.push_back('{es: es, er: er, tag: tag});
    endtask

    task automatic rd(input logic [10:0] a, input bit es, input bit er, input string tag);
        drive(1'b1, a, 1'b0, 1'b0, es, er, tag);
    endtask

    task automatic gap(input string tag);
        drive(1'b0, 11'h000, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic prefix(input string tag);
        rd(11'h000, 0, 0, tag);
        rd(11'h555, 0, 0, tag);
        rd(11'h2AA, 0, 0, tag);
        rd(11'h7FF, 0, 0, tag);
        rd(11'h0F0, 0, 0, tag);
    endtask

    // monitor: samples 2 ns after each rising edge
    always @(posedge clk_i) begin
        #2;
        if (rst_ni && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (store_req_o !== it.es || recall_req_o !== it.er) begin
                n_bad++;
                $display("FAIL %s: store/recall actual %b/%b expected %b/%b",
                         it.tag, store_req_o, recall_req_o, it.es, it.er);
            end
        end
    end

    // watchdog
    always @(posedge clk_i) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run expected finish");
            finish_run();
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk_i);
        n_cmp++;
        if (store_req_o !== 1'b0 || recall_req_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: actual %b/%b expected 0/0", store_req_o, recall_req_o);
        end
        rst_ni = 1'b1;

        // R1 save series
        prefix("R1");
        rd(11'h70F, 1, 0, "R1");
        gap("R8 single-cycle store");

        // R2 restore series
        prefix("R2");
        rd(11'h70E, 0, 1, "R2");
        gap("R8 single-cycle recall");

        // R10 idle cycles between steps
        rd(11'h000, 0, 0, "R10"); gap("R10"); gap("R10");
        rd(11'h555, 0, 0, "R10"); gap("R10");
        rd(11'h2AA, 0, 0, "R10");
        rd(11'h7FF, 0, 0, "R10"); gap("R10");
        rd(11'h0F0, 0, 0, "R10"); gap("R10"); gap("R10");
        rd(11'h70F, 1, 0, "R10");
        gap("R10");

        // R3 write mid-series
        rd(11'h000, 0, 0, "R3"); rd(11'h555, 0, 0, "R3");
        drive(1'b1, 11'h2AA, 1'b1, 1'b0, 0, 0, "R3");
        rd(11'h7FF, 0, 0, "R3"); rd(11'h0F0, 0, 0, "R3");
        rd(11'h70F, 0, 0, "R3");
        // R3 write as sixth step
        prefix("R3");
        drive(1'b1, 11'h70F, 1'b1, 1'b0, 0, 0, "R3 sixth write");
        gap("R3");

        // R4 stray read aborts
        rd(11'h000, 0, 0, "R4"); rd(11'h555, 0, 0, "R4");
        rd(11'h123, 0, 0, "R4");
        rd(11'h2AA, 0, 0, "R4"); rd(11'h7FF, 0, 0, "R4");
        rd(11'h0F0, 0, 0, "R4"); rd(11'h70F, 0, 0, "R4");
        // R4 abort at 0x000 restarts as step one
        rd(11'h000, 0, 0, "R4"); rd(11'h555, 0, 0, "R4"); rd(11'h2AA, 0, 0, "R4");
        prefix("R4 restart");
        rd(11'h70E, 0, 1, "R4 restart");
        // R4 wrong sixth at 0x000 restarts
        prefix("R4");
        rd(11'h000, 0, 0, "R4 sixth restart");
        rd(11'h555, 0, 0, "R4"); rd(11'h2AA, 0, 0, "R4");
        rd(11'h7FF, 0, 0, "R4"); rd(11'h0F0, 0, 0, "R4");
        rd(11'h70F, 1, 0, "R4 sixth restart");
        gap("R4");

        // R5 test code
        prefix("R5");
        rd(11'h39C, 0, 0, "R5");
        rd(11'h70F, 0, 0, "R5 after test code");
        gap("R5");

        // R6 repeated address
        rd(11'h000, 0, 0, "R6"); rd(11'h555, 0, 0, "R6"); rd(11'h555, 0, 0, "R6");
        rd(11'h2AA, 0, 0, "R6"); rd(11'h7FF, 0, 0, "R6");
        rd(11'h0F0, 0, 0, "R6"); rd(11'h70F, 0, 0, "R6");

        // R7 busy mid-series, then busy on sixth step
        rd(11'h000, 0, 0, "R7"); rd(11'h555, 0, 0, "R7");
        drive(1'b1, 11'h2AA, 1'b0, 1'b1, 0, 0, "R7");
        rd(11'h7FF, 0, 0, "R7"); rd(11'h0F0, 0, 0, "R7"); rd(11'h70F, 0, 0, "R7");
        prefix("R7");
        drive(1'b1, 11'h70F, 1'b0, 1'b1, 0, 0, "R7 busy sixth");
        drive(1'b0, 11'h000, 1'b0, 1'b1, 0, 0, "R7");
        prefix("R7 after busy");
        rd(11'h70F, 1, 0, "R7 after busy");

        // R11 back-to-back: save then restore with no gap
        prefix("R11");
        rd(11'h70F, 1, 0, "R11");
        rd(11'h000, 0, 0, "R11 overlap");
        rd(11'h555, 0, 0, "R11"); rd(11'h2AA, 0, 0, "R11");
        rd(11'h7FF, 0, 0, "R11"); rd(11'h0F0, 0, 0, "R11");
        rd(11'h70E, 0, 1, "R11");
        // R11 idle after success: tail of series alone does nothing
        rd(11'h555, 0, 0, "R11"); rd(11'h2AA, 0, 0, "R11");
        rd(11'h7FF, 0, 0, "R11"); rd(11'h0F0, 0, 0, "R11");
        rd(11'h70F, 0, 0, "R11 idle after success");
        gap("R11");

        repeat (4) @(negedge clk_i);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule